// File: doc/BRIEF.md
# Orthogonal 4:1:1 Chroma Output Formatter

The formatter receives a pixel stream of 8-bit luma samples. Alongside it come U and V bytes that are already one pair per four pixels and sit on an orthogonal raster. It emits one full luma sample per clock. Each four-clock pixel group carries its chroma pair as 2-bit slices on a narrow 4-line chroma port. A pixel-group strobe marks the first pixel of each group. The U and V bytes presented with that strobe are captured and then sent out most significant pair first over the group's four valid clocks.

A level-mode input picks one of two code ranges. In the standard range, luma is limited to 16..240 and chroma to ±112. In the raised range, 16 is added to luma before it is limited to 32..127, and chroma is limited to ±127. Chroma is in two's complement throughout.

An active-video flag decides what each valid clock carries. While it is low, the block sends clamp and bias codes instead of picture data: luma at the lower end of the selected range and all-zero chroma. Every output is registered, one clock after the input that produced it.

Top module: `chroma411_fmt`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier; `y_out` and `c_out` change only one clock after an input clock with `in_valid` high.
- R2: A valid clock with `grp_start` high restarts the group. The output for that clock carries U bits 7:6 on `c_out[3:2]` and V bits 7:6 on `c_out[1:0]`.
- R3: The next three valid clocks of a group carry bits 5:4, 3:2 and 1:0 on the same lines. U and V are captured only at the group start, so changes on `u_in`/`v_in` in the middle of a group have no effect.
- R4: With `lvl_alt` = 0, `y_out` is `y_in` limited to 16..240 (0x10..0xF0).
- R5: With `lvl_alt` = 1, `y_out` is `y_in` + 16, computed without wrap and limited to 32..127 (0x20..0x7F).
- R6: Chroma bytes are two's complement. They are limited before serialization, using the mode present at the group start: to -112..112 (0x90..0x70) when `lvl_alt` = 0, and to -127..127 (0x81..0x7F) when `lvl_alt` = 1.
- R7: On a valid clock with `act_vid` low, `y_out` becomes 16 (standard) or 32 (raised) and `c_out` becomes 4'b0000.
- R8: Clocks with `in_valid` low leave `y_out`, `c_out` and the group phase unchanged. This holds even when `grp_start` is high.
- R9: Synchronous active-low reset clears `out_valid`, `y_out` and `c_out` to zero. The first valid clock after reset is treated as phase 0, even without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this clock |
| grp_start | input | 1 | First pixel of a four-pixel group; U/V captured here |
| act_vid | input | 1 | High inside active video |
| lvl_alt | input | 1 | 0: standard range, 1: raised range with +16 luma |
| y_in | input | 8 | Luma sample |
| u_in | input | 8 | U byte, two's complement |
| v_in | input | 8 | V byte, two's complement |
| out_valid | output | 1 | Output sample present |
| y_out | output | 8 | Luma output |
| c_out | output | 4 | Chroma slice: [3:2] U pair, [1:0] V pair |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 2-bit slices, and the 16..240 / 32..127 luma and ±112 / ±127 chroma limits. With these values, a saturating input reaches each of the four chroma limits. An input of 0xFF in the raised range pushes the offset add past eight bits. Rebuilding the bytes from four captured slices shows exactly whether the phase order and the mid-group capture are correct. Idle clocks with a stray strobe, and a reset in the middle of a group, exercise the phase-hold and phase-restart paths.

// File: rtl/c411_pkg.sv
// Shared types for the 4:1:1 chroma output formatter.
// Assumes: the mode select is a single bit supplied at the block's edge.
package c411_pkg;

    // Code-range selection for luma offset and clipping.
    typedef enum logic {
        LVL_STD = 1'b0,
        LVL_ALT = 1'b1
    } lvl_mode_e;

endpackage

// File: rtl/c411_luma.sv
// Luma level processing: adds the optional black-level offset, limits the
// result to the selected range, and replaces it with the clamp code outside
// active video. Purely combinational; the caller registers the result.
// Assumes: clamp code equals the lower range limit of each mode.
module c411_luma
    import c411_pkg::*;
#(
    parameter int DW        = 8,
    parameter int Y_STD_LO  = 16,
    parameter int Y_STD_HI  = 240,
    parameter int Y_ALT_LO  = 32,
    parameter int Y_ALT_HI  = 127,
    parameter int Y_ALT_OFS = 16
) (
    input  lvl_mode_e       mode,
    input  logic            act,
    input  logic [DW-1:0]   y_in,
    output logic [DW-1:0]   y_nx
);

    localparam logic [DW:0] S_LO  = (DW+1)'(Y_STD_LO);
    localparam logic [DW:0] S_HI  = (DW+1)'(Y_STD_HI);
    localparam logic [DW:0] A_LO  = (DW+1)'(Y_ALT_LO);
    localparam logic [DW:0] A_HI  = (DW+1)'(Y_ALT_HI);
    localparam logic [DW:0] A_OFS = (DW+1)'(Y_ALT_OFS);

    logic [DW:0] lo;
    logic [DW:0] hi;
    logic [DW:0] sum;

    // Select the range and offset for the current mode, then clip or clamp.
    always_comb begin
        lo  = (mode == LVL_ALT) ? A_LO : S_LO;
        hi  = (mode == LVL_ALT) ? A_HI : S_HI;
        sum = {1'b0, y_in} + ((mode == LVL_ALT) ? A_OFS : '0);
        if (!act) begin
            y_nx = lo[DW-1:0];
        end else if (sum < lo) begin
            y_nx = lo[DW-1:0];
        end else if (sum > hi) begin
            y_nx = hi[DW-1:0];
        end else begin
            y_nx = sum[DW-1:0];
        end
    end

    // Guard: the processed luma never leaves the mode's range (R4, R5).
    always_comb begin
        if (!$isunknown({y_in, mode, act})) begin
            p_luma_in_range_r4: assert ({1'b0, y_nx} >= lo && {1'b0, y_nx} <= hi)
                else $error("luma outside selected range");
        end
    end

endmodule

// File: rtl/c411_cclip.sv
// Two's-complement chroma limiter: clips a signed byte symmetrically to the
// limit of the selected mode. Combinational.
// Assumes: limits are positive and below 2**(DW-1).
module c411_cclip
    import c411_pkg::*;
#(
    parameter int DW        = 8,
    parameter int C_STD_LIM = 112,
    parameter int C_ALT_LIM = 127
) (
    input  lvl_mode_e       mode,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   dout
);

    localparam logic signed [DW:0] S_LIM = (DW+1)'(C_STD_LIM);
    localparam logic signed [DW:0] A_LIM = (DW+1)'(C_ALT_LIM);

    logic signed [DW:0] x;
    logic signed [DW:0] lim;
    logic signed [DW:0] nlim;
    logic signed [DW:0] res;

    // Sign-extend, compare against both limits, saturate.
    always_comb begin
        x    = {din[DW-1], din};
        lim  = (mode == LVL_ALT) ? A_LIM : S_LIM;
        nlim = -lim;
        if (x > lim) begin
            res = lim;
        end else if (x < nlim) begin
            res = nlim;
        end else begin
            res = x;
        end
        dout = res[DW-1:0];
    end

    // Guard: the clipped value lies inside the symmetric limit (R6).
    always_comb begin
        if (!$isunknown({din, mode})) begin
            p_chroma_limit_r6: assert (res <= lim && res >= nlim)
                else $error("chroma outside limit");
        end
    end

endmodule

// File: rtl/c411_slicer.sv
// Chroma serializer: captures clipped U/V at the group strobe and emits one
// slice of each per valid clock, most significant slice first, on a
// registered port (U lane on the upper lines).
// Assumes: DW is a multiple of SLICE_W; phases follow valid clocks only.
module c411_slicer #(
    parameter int DW      = 8,
    parameter int SLICE_W = 2,
    localparam int PHASES = DW / SLICE_W,
    localparam int PH_W   = $clog2(PHASES),
    localparam int C_W    = 2 * SLICE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            grp_start,
    input  logic            act,
    input  logic [DW-1:0]   u_cl,
    input  logic [DW-1:0]   v_cl,
    output logic [C_W-1:0]  c_q
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    logic [PH_W-1:0]    ph_q;
    logic [PH_W-1:0]    cur_ph;
    logic [DW-1:0]      lane_in [2];
    logic [DW-1:0]      hold_q  [2];
    logic [DW-1:0]      cur     [2];
    logic [SLICE_W-1:0] sl      [2];

    assign lane_in[0] = u_cl;
    assign lane_in[1] = v_cl;

    // Phase of the current beat: zero at a strobe, else one past the last.
    always_comb begin
        cur_ph = grp_start ? '0 : ph_q + 1'b1;
    end

    // Per-lane source byte and slice selection.
    for (genvar l = 0; l < 2; l++) begin : g_lane
        always_comb begin
            cur[l] = grp_start ? lane_in[l] : hold_q[l];
            sl[l]  = SLICE_W'(cur[l] >> (SLICE_W * (PHASES - 1 - int'(cur_ph))));
        end
    end

    // Phase, captured bytes and output slice registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_LAST;
            c_q  <= '0;
            for (int l = 0; l < 2; l++) begin
                hold_q[l] <= '0;
            end
        end else if (in_valid) begin
            ph_q <= cur_ph;
            c_q  <= act ? {sl[0], sl[1]} : '0;
            if (grp_start) begin
                for (int l = 0; l < 2; l++) begin
                    hold_q[l] <= lane_in[l];
                end
            end
        end
    end

    // A valid strobe makes the next phase zero (R2).
    p_phase_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && grp_start |=> ph_q == '0);

    // Captured bytes do not move inside a group (R3).
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && grp_start) |=> $stable(hold_q[0]) && $stable(hold_q[1]));

    // Idle clocks freeze phase and chroma output (R8).
    p_idle_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ph_q) && $stable(c_q));

endmodule

// File: rtl/chroma411_fmt.sv
// Top of the 4:1:1 chroma output formatter: luma level processing, chroma
// limiting per lane, chroma serialization and the registered output stage.
// Assumes: inputs are synchronous to clk; U/V are valid with the strobe.
module chroma411_fmt
    import c411_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SLICE_W   = 2,
    parameter int Y_STD_LO  = 16,
    parameter int Y_STD_HI  = 240,
    parameter int Y_ALT_LO  = 32,
    parameter int Y_ALT_HI  = 127,
    parameter int Y_ALT_OFS = 16,
    parameter int C_STD_LIM = 112,
    parameter int C_ALT_LIM = 127,
    localparam int C_W      = 2 * SLICE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            grp_start,
    input  logic            act_vid,
    input  logic            lvl_alt,
    input  logic [DW-1:0]   y_in,
    input  logic [DW-1:0]   u_in,
    input  logic [DW-1:0]   v_in,
    output logic            out_valid,
    output logic [DW-1:0]   y_out,
    output logic [C_W-1:0]  c_out
);

    lvl_mode_e      mode;
    logic [DW-1:0]  y_nx;
    logic [DW-1:0]  c_raw [2];
    logic [DW-1:0]  c_cl  [2];

    assign mode     = lvl_mode_e'(lvl_alt);
    assign c_raw[0] = u_in;
    assign c_raw[1] = v_in;

    c411_luma #(
        .DW(DW), .Y_STD_LO(Y_STD_LO), .Y_STD_HI(Y_STD_HI),
        .Y_ALT_LO(Y_ALT_LO), .Y_ALT_HI(Y_ALT_HI), .Y_ALT_OFS(Y_ALT_OFS)
    ) i_luma (
        .mode (mode),
        .act  (act_vid),
        .y_in (y_in),
        .y_nx (y_nx)
    );

    for (genvar l = 0; l < 2; l++) begin : g_clip
        c411_cclip #(
            .DW(DW), .C_STD_LIM(C_STD_LIM), .C_ALT_LIM(C_ALT_LIM)
        ) i_cclip (
            .mode (mode),
            .din  (c_raw[l]),
            .dout (c_cl[l])
        );
    end

    c411_slicer #(
        .DW(DW), .SLICE_W(SLICE_W)
    ) i_slicer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .grp_start (grp_start),
        .act       (act_vid),
        .u_cl      (c_cl[0]),
        .v_cl      (c_cl[1]),
        .c_q       (c_out)
    );

    // Luma output and valid flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y_out     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y_out <= y_nx;
            end
        end
    end

    // Valid follows the input one clock later (R1).
    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // Raised range keeps luma within its window (R5).
    p_alt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && lvl_alt && act_vid |=>
            y_out >= DW'(Y_ALT_LO) && y_out <= DW'(Y_ALT_HI));

    // Blanking forces clamp luma and bias chroma (R7).
    p_blank_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !act_vid |=> c_out == '0 &&
            y_out == ($past(lvl_alt) ? DW'(Y_ALT_LO) : DW'(Y_STD_LO)));

    // Idle clocks leave luma untouched (R8).
    p_idle_luma_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(y_out));

endmodule

// File: tb/test_chroma411_fmt.sv
// Self-checking bench: table-driven groups, then directed idle, reset cases.
module test_chroma411_fmt;

    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic       alt;
        logic       act;
        logic [7:0] u;
        logic [7:0] v;
        logic [7:0] y;
        logic [7:0] eu;
        logic [7:0] ev;
        logic [7:0] ey;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 8'h35, 8'hCA, 8'h80, 8'h35, 8'hCA, 8'h80},
        '{1'b0, 1'b1, 8'h7F, 8'h80, 8'h05, 8'h70, 8'h90, 8'h10},
        '{1'b0, 1'b1, 8'h70, 8'h90, 8'hF0, 8'h70, 8'h90, 8'hF0},
        '{1'b0, 1'b1, 8'h71, 8'h8F, 8'hF1, 8'h70, 8'h90, 8'hF0},
        '{1'b1, 1'b1, 8'h7F, 8'h80, 8'h00, 8'h7F, 8'h81, 8'h20},
        '{1'b1, 1'b1, 8'h81, 8'h12, 8'h50, 8'h81, 8'h12, 8'h60},
        '{1'b1, 1'b1, 8'hA5, 8'h5A, 8'h70, 8'hA5, 8'h5A, 8'h7F},
        '{1'b0, 1'b0, 8'h55, 8'hAA, 8'h99, 8'h00, 8'h00, 8'h10},
        '{1'b1, 1'b0, 8'h55, 8'hAA, 8'h99, 8'h00, 8'h00, 8'h20},
        '{1'b1, 1'b1, 8'h00, 8'hFF, 8'h6F, 8'h00, 8'hFF, 8'h7F},
        '{1'b1, 1'b1, 8'h3C, 8'hC3, 8'hFF, 8'h3C, 8'hC3, 8'h7F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       grp_start = 1'b0;
    logic       act_vid = 1'b0;
    logic       lvl_alt = 1'b0;
    logic [7:0] y_in = '0;
    logic [7:0] u_in = '0;
    logic [7:0] v_in = '0;
    logic       out_valid;
    logic [7:0] y_out;
    logic [3:0] c_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    chroma411_fmt i_chroma411_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .grp_start (grp_start),
        .act_vid   (act_vid),
        .lvl_alt   (lvl_alt),
        .y_in      (y_in),
        .u_in      (u_in),
        .v_in      (v_in),
        .out_valid (out_valid),
        .y_out     (y_out),
        .c_out     (c_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one beat at a falling edge; outputs are ready at the next one.
    task automatic beat(input bit st, input bit act, input bit alt,
                        input logic [7:0] y, input logic [7:0] u, input logic [7:0] v);
        in_valid  = 1'b1;
        grp_start = st;
        act_vid   = act;
        lvl_alt   = alt;
        y_in      = y;
        u_in      = u;
        v_in      = v;
        @(negedge clk);
    endtask

    task automatic run_group(input vec_t t);
        logic [7:0] gu;
        logic [7:0] gv;
        string      yreq;
        gu   = '0;
        gv   = '0;
        yreq = !t.act ? "R7" : (t.alt ? "R5" : "R4");
        for (int k = 0; k < 4; k++) begin
            // Mid-group bytes are inverted: they must be ignored (R3).
            beat(k == 0, t.act, t.alt, t.y, (k == 0) ? t.u : ~t.u, (k == 0) ? t.v : ~t.v);
            chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
            chk(y_out == t.ey, yreq, int'(y_out), int'(t.ey));
            if (k == 0) begin
                chk(c_out == {t.eu[7:6], t.ev[7:6]}, "R2", int'(c_out),
                    int'({t.eu[7:6], t.ev[7:6]}));
            end
            gu = {gu[5:0], c_out[3:2]};
            gv = {gv[5:0], c_out[1:0]};
        end
        in_valid = 1'b0;
        chk(gu == t.eu, t.act ? "R3 R6 U" : "R7 U", int'(gu), int'(t.eu));
        chk(gv == t.ev, t.act ? "R3 R6 V" : "R7 V", int'(gv), int'(t.ev));
    endtask

    initial begin
        logic [7:0] gu;
        logic [7:0] gv;
        logic [3:0] c_hold;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
        chk(y_out == 8'h00, "R9", int'(y_out), 0);
        chk(c_out == 4'h0, "R9", int'(c_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

        for (int i = 0; i < NV; i++) begin
            run_group(TBL[i]);
        end

        // R8: idle clocks inside a group, with a stray strobe and new data
        gu = '0;
        gv = '0;
        beat(1'b1, 1'b1, 1'b1, 8'h40, 8'h5C, 8'hA3);
        gu = {gu[5:0], c_out[3:2]};
        gv = {gv[5:0], c_out[1:0]};
        beat(1'b0, 1'b1, 1'b1, 8'h40, 8'h00, 8'h00);
        gu = {gu[5:0], c_out[3:2]};
        gv = {gv[5:0], c_out[1:0]};
        c_hold    = c_out;
        in_valid  = 1'b0;
        grp_start = 1'b1;
        y_in      = 8'h10;
        u_in      = 8'hFF;
        v_in      = 8'hFF;
        act_vid   = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(y_out == 8'h50, "R8", int'(y_out), 8'h50);
        chk(c_out == c_hold, "R8", int'(c_out), int'(c_hold));
        beat(1'b0, 1'b1, 1'b1, 8'h40, 8'h11, 8'h22);
        gu = {gu[5:0], c_out[3:2]};
        gv = {gv[5:0], c_out[1:0]};
        beat(1'b0, 1'b1, 1'b1, 8'h40, 8'h33, 8'h44);
        gu = {gu[5:0], c_out[3:2]};
        gv = {gv[5:0], c_out[1:0]};
        in_valid = 1'b0;
        chk(gu == 8'h5C, "R8 U", int'(gu), 8'h5C);
        chk(gv == 8'hA3, "R8 V", int'(gv), 8'hA3);

        // R9: reset in mid-group, then a group without a strobe
        beat(1'b1, 1'b1, 1'b0, 8'h80, 8'h12, 8'h34);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
        chk(y_out == 8'h00, "R9", int'(y_out), 0);
        chk(c_out == 4'h0, "R9", int'(c_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        gu = '0;
        gv = '0;
        for (int k = 0; k < 4; k++) begin
            beat(1'b0, 1'b1, 1'b0, 8'h80, 8'hEE, 8'h77);
            gu = {gu[5:0], c_out[3:2]};
            gv = {gv[5:0], c_out[1:0]};
        end
        in_valid = 1'b0;
        // Captured bytes were cleared by reset, so phase 0 starts at the top.
        chk(gu == 8'h00, "R9 U", int'(gu), 0);
        chk(gv == 8'h00, "R9 V", int'(gv), 0);
        run_group(TBL[0]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule